// File: doc/BRIEF.md
# Software Store/Recall Key Detector

This block sits behind the synchronisers of an asynchronous-style SRAM port and watches the chip-enable-controlled access cycles. It looks for a fixed key of six consecutive read accesses. The first five key addresses must match in order. The sixth address chooses between a request to copy the SRAM into non-volatile cells (store) and a request to reload the SRAM from them (recall). On an exact, uninterrupted key it raises a one-cycle request pulse toward the transfer engine. It also asserts a hold output that disables the array and floats the data bus for a fixed number of clock cycles.

A key step is taken only on a falling edge of chip enable with write enable high. Output enable plays no part. Only the lower fourteen address bits are compared. Any write, or any read of a wrong address, throws away the partial key. An aborting read of the first key address starts a new key at once. A store request is refused while the supply monitor reports the supply below its switch threshold. The first five key reads are ordinary reads, and this block does not interfere with them.

Top module: `nv_key_detector`

## Requirements
- R1: After synchronous reset, store_req, recall_req and array_hold are 0 and key_step is 0.
- R2: A key step is taken only in the clock cycle that sees chip enable fall (ce_n sampled 1 then 0) with we_n high. All outputs are registered, so they show the step one clock edge after ce_n is first sampled low. Holding ce_n low, or changing the address while it is low, takes no further step.
- R3: key_step counts the key reads matched so far, from 0 to 5. The matching read addresses, in order, are 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F.
- R4: A sixth read at address 0x0FC0 taken at step 5, with supply_ok high, produces a store_req pulse exactly one cycle wide and returns key_step to 0.
- R5: A sixth read at address 0x0C63 taken at step 5 produces a recall_req pulse exactly one cycle wide and returns key_step to 0. This happens whatever the level of supply_ok.
- R6: Address bit 14 is ignored in every comparison.
- R7: A write aborts the key and sets key_step to 0. A write is a cycle in which ce_n and we_n are both low, whether we_n is low at the chip-enable fall or goes low later in the cycle.
- R8: A read that does not match the expected key address aborts the key. key_step becomes 1 if that address is 0x0E38, and 0 otherwise. No request is made.
- R9: array_hold rises in the same cycle as a request pulse. It stays high for STORE_LEN cycles after a store and for RECALL_LEN cycles after a recall.
- R10: Access cycles are ignored while array_hold is high. key_step is 0 during the hold and after it ends.
- R11: A store key completed while supply_ok is low makes no request and no hold, and key_step returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Synchronised chip enable, active low |
| we_n | input | 1 | Synchronised write enable, active low |
| addr | input | ADDR_W (15) | Synchronised access address |
| supply_ok | input | 1 | High when the supply is above the switch threshold |
| store_req | output | 1 | One-cycle store request pulse |
| recall_req | output | 1 | One-cycle recall request pulse |
| array_hold | output | 1 | Array disabled and data bus floated while high |
| key_step | output | 3 | Number of key reads matched so far (0 to 5) |

## Verification
A corrupted step register shows on key_step one clock edge after the access that caused it. An undetected abort turns into a spurious request pulse as soon as the sixth key read arrives. A step that goes wrong by skipping or stalling makes an exact key produce no pulse at all. A wrong hold counter shows as a hold that is too short or too long, measured against the store and recall lengths. An event that should be ignored but leaks through during the hold shows as a nonzero key_step or as a request while array_hold is high.

// File: rtl/nvk_pkg.sv
package nvk_pkg;
  localparam int KEY_W   = 14;
  localparam int PREFIX  = 5;
  localparam int STEP_W  = $clog2(PREFIX + 1);

  typedef logic [KEY_W-1:0] key_t;

  localparam key_t STORE_TAIL  = 14'h0FC0;
  localparam key_t RECALL_TAIL = 14'h0C63;

  function automatic key_t prefix_key(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      default: return 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvk_access_sense.sv
module nvk_access_sense (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic rd_evt,
  output logic wr_evt
);
  logic ce_q;

  always_ff @(posedge clk) begin
    if (rst) ce_q <= 1'b1;
    else     ce_q <= ce_n;
  end

  assign rd_evt = ce_q & ~ce_n & we_n;
  assign wr_evt = ~ce_n & ~we_n;

  // A read event needs a fresh chip-enable fall: never two in a row
  p_single_event_r2: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> !rd_evt);
endmodule

// File: rtl/nvk_seq_fsm.sv
module nvk_seq_fsm
  import nvk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  key_t              key_addr,
  input  logic              supply_ok,
  input  logic              busy,
  output logic [STEP_W-1:0] step_q,
  output logic              hit_store,
  output logic              hit_recall,
  output logic              store_req,
  output logic              recall_req
);
  logic [PREFIX-1:0] pre_hit;
  logic              cur_hit;
  logic              tail_store;
  logic              tail_recall;
  logic [STEP_W-1:0] step_d;

  for (genvar g = 0; g < PREFIX; g++) begin : g_cmp
    assign pre_hit[g] = (key_addr == prefix_key(g));
  end

  assign tail_store  = (key_addr == STORE_TAIL);
  assign tail_recall = (key_addr == RECALL_TAIL);

  always_comb begin
    cur_hit = 1'b0;
    for (int i = 0; i < PREFIX; i++) begin
      if (step_q == STEP_W'(i)) cur_hit = pre_hit[i];
    end
  end

  always_comb begin
    step_d     = step_q;
    hit_store  = 1'b0;
    hit_recall = 1'b0;
    if (busy) begin
      step_d = '0;
    end else if (wr_evt) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (step_q < STEP_W'(PREFIX)) begin
        if (cur_hit)         step_d = step_q + STEP_W'(1);
        else if (pre_hit[0]) step_d = STEP_W'(1);
        else                 step_d = '0;
      end else if (tail_store && supply_ok) begin
        hit_store = 1'b1;
        step_d    = '0;
      end else if (tail_recall) begin
        hit_recall = 1'b1;
        step_d     = '0;
      end else if (pre_hit[0]) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step_q     <= step_d;
      store_req  <= hit_store;
      recall_req <= hit_recall;
    end
  end

  p_req_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req}));

  p_store_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);

  p_recall_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);

  p_store_supply_r11: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(supply_ok));

  p_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> step_q == '0);

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    (step_q > $past(step_q)) |-> (step_q == $past(step_q) + STEP_W'(1)));

  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    step_q <= STEP_W'(PREFIX));
endmodule

// File: rtl/nvk_op_timer.sv
module nvk_op_timer #(
  parameter int STORE_LEN  = 5000,
  parameter int RECALL_LEN = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_store,
  input  logic start_recall,
  output logic busy
);
  localparam int MAX_LEN = (STORE_LEN > RECALL_LEN) ? STORE_LEN : RECALL_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && start_store) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(STORE_LEN - 1);
    end else if (!busy && start_recall) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(RECALL_LEN - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start_store || start_recall) |=> busy);

  p_no_start_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(start_store || start_recall));
endmodule

// File: rtl/nv_key_detector.sv
module nv_key_detector
  import nvk_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int STORE_LEN  = 5000,
  parameter int RECALL_LEN = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              supply_ok,
  output logic              store_req,
  output logic              recall_req,
  output logic              array_hold,
  output logic [STEP_W-1:0] key_step
);
  logic rd_evt;
  logic wr_evt;
  logic hit_store;
  logic hit_recall;
  key_t key_addr;

  assign key_addr = addr[KEY_W-1:0];

  nvk_access_sense u_sense (
    .clk    (clk),
    .rst    (rst),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .rd_evt (rd_evt),
    .wr_evt (wr_evt)
  );

  nvk_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .key_addr   (key_addr),
    .supply_ok  (supply_ok),
    .busy       (array_hold),
    .step_q     (key_step),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .store_req  (store_req),
    .recall_req (recall_req)
  );

  nvk_op_timer #(
    .STORE_LEN  (STORE_LEN),
    .RECALL_LEN (RECALL_LEN)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start_store  (hit_store),
    .start_recall (hit_recall),
    .busy         (array_hold)
  );

  p_req_with_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> array_hold);

  p_idle_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
    array_hold |-> key_step == '0);
endmodule

// File: tb/tb_nv_key_detector.sv
`timescale 1ns/1ps
module tb_nv_key_detector;
  localparam int SLEN = 20;
  localparam int RLEN = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic [14:0] addr = '0;
  logic supply_ok = 1'b1;
  logic store_req, recall_req, array_hold;
  logic [2:0] key_step;

  int checks = 0;
  int errors = 0;
  int es = 0;

  always #2 clk = ~clk;

  nv_key_detector #(.ADDR_W(15), .STORE_LEN(SLEN), .RECALL_LEN(RLEN)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .supply_ok(supply_ok), .store_req(store_req), .recall_req(recall_req),
    .array_hold(array_hold), .key_step(key_step)
  );

  function automatic logic [13:0] kk(input int i);
    case (i)
      0: return 14'h0E38;
      1: return 14'h31C7;
      2: return 14'h03E0;
      3: return 14'h3C1F;
      4: return 14'h303F;
      5: return 14'h0FC0;
      default: return 14'h0C63;
    endcase
  endfunction

  function automatic void model(input int s, input logic [14:0] a, input logic w,
                                input logic sup, output int ns, output int fire);
    logic [13:0] k;
    k = a[13:0];
    fire = 0;
    if (!w) ns = 0;
    else if (s < 5) ns = (k == kk(s)) ? s + 1 : ((k == kk(0)) ? 1 : 0);
    else if (k == kk(5) && sup) begin fire = 1; ns = 0; end
    else if (k == kk(6)) begin fire = 2; ns = 0; end
    else ns = (k == kk(0)) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One access: ce_n falls at a negedge, outputs checked one edge later.
  task automatic acc(input logic [14:0] a, input logic w, input logic sup, input string req);
    int ns, fire, cnt;
    model(es, a, w, sup, ns, fire);
    @(negedge clk);
    ce_n = 1'b0; we_n = w; addr = a; supply_ok = sup;
    @(posedge clk); @(negedge clk);
    chk({req, " step"}, key_step, ns);
    chk({req, " store_req"}, store_req, fire == 1);
    chk({req, " recall_req"}, recall_req, fire == 2);
    chk({req, " hold"}, array_hold, fire != 0);
    es = ns;
    if (fire != 0) begin
      cnt = 1;
      for (int i = 0; i < 1000; i++) begin
        @(posedge clk); @(negedge clk);
        if (i == 0) begin
          ce_n = 1'b1; we_n = 1'b1;
          chk("R4/R5 single-cycle pulse", store_req | recall_req, 0);
        end
        if (array_hold) cnt++;
        else break;
      end
      chk("R9 hold length", cnt, (fire == 1) ? SLEN : RLEN);
      chk("R10 step after hold", key_step, 0);
    end else begin
      @(posedge clk); @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      @(posedge clk);
    end
  endtask

  task automatic key5(input logic b14);
    for (int i = 0; i < 5; i++) acc({b14, kk(i)}, 1'b1, 1'b1, "R3 key");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r, ns, fire;
    logic [14:0] a;
    logic w, sup;
    r = $urandom(32'd7331);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 store_req", store_req, 0);
    chk("R1 recall_req", recall_req, 0);
    chk("R1 hold", array_hold, 0);
    chk("R1 step", key_step, 0);

    // R4 store with bit 14 set on some steps (R6)
    acc({1'b1, kk(0)}, 1, 1, "R6 b14");
    for (int i = 1; i < 5; i++) acc({i[0], kk(i)}, 1, 1, "R6 key");
    acc({1'b1, kk(5)}, 1, 1, "R4 store");
    // R5 recall
    key5(1'b0);
    acc({1'b0, kk(6)}, 1, 1, "R5 recall");
    // R7 write at fall aborts
    acc({1'b0, kk(0)}, 1, 1, "R7 pre");
    acc({1'b0, kk(1)}, 1, 1, "R7 pre");
    acc({1'b0, kk(2)}, 0, 1, "R7 write");
    chk("R7 aborted", key_step, 0);
    // R8 mismatch, restart on first key address
    key5(1'b0);
    acc({1'b0, 14'h1234}, 1, 1, "R8 mismatch");
    acc({1'b0, kk(0)}, 1, 1, "R8 k0");
    acc({1'b0, kk(1)}, 1, 1, "R8 k1");
    acc({1'b0, kk(0)}, 1, 1, "R8 restart");
    chk("R8 restart step", key_step, 1);
    key5(1'b0);
    acc({1'b0, kk(0)}, 1, 1, "R8 tail restart");
    chk("R8 tail restart step", key_step, 1);
    acc({1'b0, 14'h0000}, 1, 1, "R8 clear");
    // R11 store refused on low supply; recall still allowed
    key5(1'b0);
    acc({1'b0, kk(5)}, 1, 0, "R11 low store");
    chk("R11 no hold", array_hold, 0);
    key5(1'b0);
    acc({1'b0, kk(6)}, 1, 0, "R5 low recall");

    // R7 write that starts later in the cycle
    acc({1'b0, kk(0)}, 1, 1, "R7 mid pre");
    acc({1'b0, kk(1)}, 1, 1, "R7 mid pre");
    @(negedge clk); ce_n = 0; we_n = 1; addr = {1'b0, kk(2)};
    @(posedge clk); @(negedge clk);
    chk("R7 mid read step", key_step, 3);
    we_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 mid write abort", key_step, 0);
    ce_n = 1; we_n = 1; es = 0;
    @(posedge clk);

    // R2 address change while ce_n held low takes no step
    @(negedge clk); ce_n = 0; addr = {1'b0, kk(0)};
    @(posedge clk); @(negedge clk);
    chk("R2 first", key_step, 1);
    addr = {1'b0, kk(1)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 held low", key_step, 1);
    ce_n = 1; es = 1;
    @(posedge clk);
    acc({1'b0, kk(1)}, 1, 1, "R2 next fall");
    acc({1'b0, 14'h2222}, 1, 1, "R2 clear");

    // R10 accesses during hold are ignored
    key5(1'b0);
    @(negedge clk); ce_n = 0; addr = {1'b0, kk(6)};
    @(posedge clk); @(negedge clk);
    chk("R10 recall fired", recall_req, 1);
    ce_n = 1;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk); ce_n = 0; addr = {1'b0, kk(j)};
      @(posedge clk); @(negedge clk);
      chk("R10 step in hold", key_step, 0);
      chk("R10 no req in hold", store_req | recall_req, 0);
      ce_n = 1;
    end
    for (int i = 0; i < 100 && array_hold; i++) @(negedge clk);
    chk("R10 step after hold", key_step, 0);
    es = 0;
    acc({1'b0, kk(0)}, 1, 1, "R10 alive");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      r = $urandom % 10;
      if (r < 6) begin
        if (es < 5) a[13:0] = kk(es);
        else a[13:0] = ($urandom % 2) ? kk(5) : kk(6);
      end else if (r == 6) a[13:0] = kk(0);
      else if (r == 7) a[13:0] = ($urandom % 2) ? kk(5) : kk(6);
      else a[13:0] = 14'($urandom);
      a[14] = 1'($urandom);
      w = ($urandom % 10) != 0;
      sup = ($urandom % 6) != 0;
      acc(a, w, sup, "R3/R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule